// File: doc/BRIEF.md
# PWM Fault and Retrigger Input Unit

This unit takes one external fault or retrigger signal, picks it from either a device pin or an analog comparator output, removes short glitches with a fixed-length digital filter, and qualifies it with a programmable active level and an enable. The qualified signal is turned into commands for a PWM sequencer that runs four ramps per cycle: dead time of side A, on time of side A, dead time of side B, and on time of side B. The unit never counts time itself. It watches the ramp index and the end-of-ramp strobe from the sequencer, and returns a small set of commands: load a ramp index, freeze the counter, force both outputs inactive, restart the cycle, or halt.

A 3-bit behaviour code selects what an active fault does, relative to the ramp in progress. A separate edge-retrigger enable overrides the behaviour code. In that case each newly active edge restarts the cycle from its first ramp. Two software strobes complete the interface. One halts the generator and cancels any fault-driven wait. The other releases the generator from a halt.

Top module: `fault_input_unit`

## Requirements
- R1: `src_sel_i` = 0 takes the fault from `pin_i`, and `src_sel_i` = 1 takes it from `cmp_i`. The unselected source has no effect on any output.
- R2: With `bypass_i` = 0, a change of the selected source reaches the commands only after FILT_LEN+1 consecutive equal samples. With FILT_LEN = 4, a level applied before edge k first acts in the cycle after edge k+4, and pulses of 4 cycles or fewer are dropped.
- R3: With `bypass_i` = 1, the source is registered once, so a level applied before edge k acts in the cycle after edge k. That is 4 cycles earlier than the filtered path.
- R4: The fault is active when the filtered level equals `act_high_i`. It is active only while `enable_i` = 1, and with `enable_i` = 0 no command is issued.
- R5: With `edge_rtg_i` = 1, each inactive-to-active transition gives a one-cycle `restart_o` pulse. In that case the behaviour code issues no command, and a halted unit gives no restart.
- R6: Ramp indices are 0 (dead time A), 1 (on time A), 2 (dead time B) and 3 (on time B), and the opposite dead time of index 0 or 1 is 2, and of index 2 or 3 is 0. Codes 1 and 6 pulse `jump_o` to the opposite dead time in the first active cycle. They then assert `hold_o` from the next cycle until the cycle after the fault goes inactive.
- R7: Code 2 jumps to the opposite dead time and lets it run. It asserts `hold_o` from the cycle where `ramp_end_i` is high, and keeps it asserted until the fault goes inactive.
- R8: Code 3 jumps to the opposite dead time. While the fault stays active, the end of the opposite on-time ramp jumps back to that dead time. Other ramp ends cause no jump, and release stops the loop.
- R9: Code 4 asserts `off_o` in every cycle in which the fault is active, and issues no jump, hold or halt.
- R10: Code 5 jumps once to the opposite dead time. It issues no hold and no further jump until the fault has gone inactive.
- R11: Code 7 asserts `halt_o`, `hold_o` and `off_o` from the cycle after the fault. Further fault activity leaves the unit halted. A `run_set_i` pulse returns it to normal operation.
- R12: `run_clr_i` halts the unit in the next cycle from any state, cancelling a wait or hold, and takes priority over `run_set_i`.
- R13: After reset, and for code 0, all command outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Fault source from pin |
| cmp_i | input | 1 | Fault source from comparator |
| src_sel_i | input | 1 | Source select (1 = comparator) |
| bypass_i | input | 1 | Skip the glitch filter |
| act_high_i | input | 1 | Active level of the fault |
| enable_i | input | 1 | Fault input enable |
| edge_rtg_i | input | 1 | Edge-retrigger enable |
| mode_i | input | 3 | Fault behaviour code |
| ramp_i | input | 2 | Current ramp index from sequencer |
| ramp_end_i | input | 1 | Current ramp ends this cycle |
| run_set_i | input | 1 | Software restart from halt |
| run_clr_i | input | 1 | Software halt |
| jump_o | output | 1 | Load ramp index `jump_ramp_o` |
| jump_ramp_o | output | 2 | Ramp index to load |
| hold_o | output | 1 | Freeze sequencer counter |
| off_o | output | 1 | Force both PWM outputs inactive |
| restart_o | output | 1 | Restart cycle at ramp 0 |
| halt_o | output | 1 | Generator halted |

## Verification
The assertions check these properties on every cycle:
- A filtered edge is always backed by earlier samples of the same level.
- Restart and jump never occur together, and a restart is never paired with a hold.
- No jump is issued while the unit is halted.
- A halt persists until software releases it, and a software halt takes effect in the next cycle.
- A released wait drops its hold.

The scenarios are needed for the rest. They cover the exact filter latency and the glitch width it rejects, and the choice of opposite dead time for each ramp. They also cover the mode 3 loop back at the end of the opposite on time, and the fact that fault activity is ignored during a halt.

// File: rtl/fault_unit_pkg.sv
package fault_unit_pkg;
  localparam int MODE_W = 3;
  localparam int RAMP_W = 2;

  typedef enum logic [MODE_W-1:0] {
    FM_NONE      = 3'd0,
    FM_JUMP_WAIT = 3'd1,
    FM_JUMP_RUN  = 3'd2,
    FM_OPP_LOOP  = 3'd3,
    FM_OUT_OFF   = 3'd4,
    FM_DT_INSERT = 3'd5,
    FM_JUMP_ALT  = 3'd6,
    FM_HALT      = 3'd7
  } fault_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DRAIN,
    ST_LOOP,
    ST_SPENT,
    ST_HALT
  } ctrl_state_e;
endpackage

// File: rtl/fault_filter.sv
module fault_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic bypass_i,
  output logic filt_o
);
  localparam int SH_TOP = FILT_LEN - 1;

  logic [SH_TOP:0] sh_q;
  logic            filt_q;
  logic            all_one, all_zero;

  assign all_one  = (&sh_q) & raw_i;
  assign all_zero = ~(|sh_q) & ~raw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      filt_q <= 1'b0;
    end else begin
      sh_q <= {sh_q[SH_TOP-1:0], raw_i};
      if (bypass_i)      filt_q <= raw_i;
      else if (all_one)  filt_q <= 1'b1;
      else if (all_zero) filt_q <= 1'b0;
    end
  end

  assign filt_o = filt_q;

  // R2
  filt_backed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(filt_q) && !$past(bypass_i)) |-> ($past(raw_i) == filt_q && $past(raw_i, 2) == filt_q));
endmodule

// File: rtl/fault_detect.sv
module fault_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic filt_i,
  input  logic act_high_i,
  input  logic enable_i,
  output logic act_o,
  output logic rise_o
);
  logic act_q;

  assign act_o  = enable_i & (act_high_i ? filt_i : ~filt_i);
  assign rise_o = act_o & ~act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_o;
  end

  // R4
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fault_ctrl.sv
module fault_ctrl
  import fault_unit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              rise_i,
  input  logic              edge_rtg_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [RAMP_W-1:0] ramp_i,
  input  logic              ramp_end_i,
  input  logic              run_set_i,
  input  logic              run_clr_i,
  output logic              jump_o,
  output logic [RAMP_W-1:0] jump_ramp_o,
  output logic              hold_o,
  output logic              off_o,
  output logic              restart_o,
  output logic              halt_o
);
  ctrl_state_e st_q, st_d;
  fault_mode_e mode;
  logic        side_q;
  logic        trig, jump_mode, loop_back;

  assign mode = fault_mode_e'(mode_i);
  assign trig = (st_q == ST_IDLE) & act_i & ~edge_rtg_i;

  always_comb begin
    jump_mode = 1'b0;
    unique case (mode)
      FM_JUMP_WAIT, FM_JUMP_RUN, FM_OPP_LOOP, FM_DT_INSERT, FM_JUMP_ALT: jump_mode = 1'b1;
      default: jump_mode = 1'b0;
    endcase
  end

  assign loop_back = (st_q == ST_LOOP) & act_i & ramp_end_i & (ramp_i == {side_q, 1'b1});

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (trig) begin
        unique case (mode)
          FM_JUMP_WAIT, FM_JUMP_ALT: st_d = ST_WAIT;
          FM_JUMP_RUN:               st_d = ST_DRAIN;
          FM_OPP_LOOP:               st_d = ST_LOOP;
          FM_DT_INSERT:              st_d = ST_SPENT;
          FM_HALT:                   st_d = ST_HALT;
          default:                   st_d = ST_IDLE;
        endcase
      end
      ST_WAIT, ST_LOOP, ST_SPENT: if (!act_i) st_d = ST_IDLE;
      ST_DRAIN: begin
        if (!act_i)          st_d = ST_IDLE;
        else if (ramp_end_i) st_d = ST_WAIT;
      end
      ST_HALT: if (run_set_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (run_clr_i) st_d = ST_HALT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      side_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (trig) side_q <= ~ramp_i[1];
    end
  end

  assign jump_o      = (trig & jump_mode) | loop_back;
  assign jump_ramp_o = (st_q == ST_IDLE) ? {~ramp_i[1], 1'b0} : {side_q, 1'b0};
  assign hold_o      = (st_q == ST_WAIT) | (st_q == ST_HALT) |
                       ((st_q == ST_DRAIN) & act_i & ramp_end_i);
  assign off_o       = (st_q == ST_HALT) | (trig & (mode == FM_OUT_OFF));
  assign restart_o   = (st_q == ST_IDLE) & edge_rtg_i & rise_i;
  assign halt_o      = (st_q == ST_HALT);

  // R5
  cmd_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({jump_o, restart_o}));
  // R5
  restart_no_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> !hold_o);
  // R11
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !run_set_i) |=> halt_o);
  // R11
  halt_no_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !jump_o);
  // R12
  run_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_clr_i |=> halt_o);
  // R6
  wait_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !act_i && !run_clr_i) |=> !hold_o);
endmodule

// File: rtl/fault_input_unit.sv
module fault_input_unit
  import fault_unit_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic              cmp_i,
  input  logic              src_sel_i,
  input  logic              bypass_i,
  input  logic              act_high_i,
  input  logic              enable_i,
  input  logic              edge_rtg_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [RAMP_W-1:0] ramp_i,
  input  logic              ramp_end_i,
  input  logic              run_set_i,
  input  logic              run_clr_i,
  output logic              jump_o,
  output logic [RAMP_W-1:0] jump_ramp_o,
  output logic              hold_o,
  output logic              off_o,
  output logic              restart_o,
  output logic              halt_o
);
  logic raw, filt, act, rise;

  assign raw = src_sel_i ? cmp_i : pin_i;

  fault_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk_i, .rst_ni, .raw_i(raw), .bypass_i, .filt_o(filt)
  );

  fault_detect u_detect (
    .clk_i, .rst_ni, .filt_i(filt), .act_high_i, .enable_i,
    .act_o(act), .rise_o(rise)
  );

  fault_ctrl u_ctrl (
    .clk_i, .rst_ni, .act_i(act), .rise_i(rise), .edge_rtg_i, .mode_i,
    .ramp_i, .ramp_end_i, .run_set_i, .run_clr_i,
    .jump_o, .jump_ramp_o, .hold_o, .off_o, .restart_o, .halt_o
  );
endmodule

// File: tb/fault_input_unit_test.sv
module fault_input_unit_test;
  localparam int FILT_LEN = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pin = 0, cmp = 0, src_sel = 0, bypass = 0, act_high = 1, enable = 0, edge_rtg = 0;
  logic [2:0] mode = 0;
  logic [1:0] ramp = 0;
  logic ramp_end = 0, run_set = 0, run_clr = 0;
  logic jump, hold, off, restart, halt;
  logic [1:0] jump_ramp;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  fault_input_unit #(.FILT_LEN(FILT_LEN)) uut (
    .clk_i(clk), .rst_ni, .pin_i(pin), .cmp_i(cmp), .src_sel_i(src_sel),
    .bypass_i(bypass), .act_high_i(act_high), .enable_i(enable), .edge_rtg_i(edge_rtg),
    .mode_i(mode), .ramp_i(ramp), .ramp_end_i(ramp_end), .run_set_i(run_set),
    .run_clr_i(run_clr), .jump_o(jump), .jump_ramp_o(jump_ramp), .hold_o(hold),
    .off_o(off), .restart_o(restart), .halt_o(halt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_all();
    pin = 0; cmp = 0; ramp_end = 0;
    repeat (3) tick();
    run_set = 1; tick(); run_set = 0; tick();
  endtask

  function automatic string mode_req(input int m);
    case (m)
      0: return "R13 code0";
      1, 6: return "R6 jump-wait";
      2: return "R7 jump-run";
      3: return "R8 loop";
      4: return "R9 off";
      5: return "R10 insert";
      default: return "R11 halt";
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    repeat (3) tick();
    rst_ni = 1;
    tick();
    // R13 reset state
    chk("R13 reset", {jump, hold, off, restart, halt}, 0);

    // R2 glitch width sweep (filtered, mode 4 observed on off_o)
    enable = 1; mode = 4; act_high = 1; bypass = 0;
    for (int w = 1; w <= 7; w++) begin
      seen = 0;
      pin = 1;
      repeat (w) begin tick(); seen |= off; end
      pin = 0;
      repeat (FILT_LEN + 3) begin tick(); seen |= off; end
      chk($sformatf("R2 pulse w=%0d", w), seen, (w >= FILT_LEN + 1));
      repeat (FILT_LEN + 3) tick();
    end

    // R2 latency
    pin = 1; n = 0;
    while (!off && n < 20) begin tick(); n++; end
    chk("R2 latency", n, FILT_LEN + 1);
    pin = 0; repeat (10) tick();

    // R3 bypass latency
    bypass = 1;
    pin = 1; n = 0;
    while (!off && n < 20) begin tick(); n++; end
    chk("R3 latency", n, 1);
    pin = 0; repeat (3) tick();

    // R1 source select
    src_sel = 1; pin = 1; cmp = 0; tick(); tick();
    chk("R1 pin ignored", off, 0);
    cmp = 1; tick();
    chk("R1 cmp used", off, 1);
    src_sel = 0; pin = 0; cmp = 0; tick(); tick();
    chk("R1 back to pin", off, 0);

    // R4 polarity and enable
    act_high = 0; pin = 1; tick(); tick();
    chk("R4 high inactive", off, 0);
    pin = 0; tick();
    chk("R4 low active", off, 1);
    enable = 0; #1;
    chk("R4 disabled", off, 0);
    tick();
    chk("R4 disabled held", {off, jump, hold, halt}, 0);
    enable = 1; act_high = 1; pin = 0; tick(); tick();

    // R6-R11, R13 sweep over behaviour codes and ramps
    for (int m = 0; m < 8; m++) begin
      for (int r = 0; r < 4; r++) begin
        bit ej;
        idle_all();
        mode = 3'(m); ramp = 2'(r);
        ej = (m == 1 || m == 2 || m == 3 || m == 5 || m == 6);
        pin = 1; tick();
        chk({mode_req(m), " jump"}, jump, ej);
        if (ej) chk({mode_req(m), " target"}, jump_ramp, (r < 2) ? 2 : 0);
        chk({mode_req(m), " off"}, off, (m == 4));
        tick();
        chk({mode_req(m), " hold"}, hold, (m == 1 || m == 6 || m == 7));
        chk({mode_req(m), " halt"}, halt, (m == 7));
        chk({mode_req(m), " no rejump"}, jump, 0);
        pin = 0; tick(); tick();
        chk({mode_req(m), " release"}, hold, (m == 7));
      end
    end
    idle_all();

    // R6 hold persists while active, drops one cycle after release edge
    mode = 1; ramp = 3; pin = 1; tick(); repeat (5) tick();
    chk("R6 hold active", hold, 1);
    pin = 0; tick();
    chk("R6 hold until state update", hold, 1);
    tick();
    chk("R6 hold released", hold, 0);
    idle_all();

    // R7 drain then hold
    mode = 2; ramp = 1; pin = 1; tick();
    chk("R7 jump", {jump, jump_ramp}, {1'b1, 2'd2});
    tick();
    chk("R7 no hold during dt", hold, 0);
    ramp = 2; ramp_end = 1; #1;
    chk("R7 hold at end", hold, 1);
    tick(); ramp_end = 0; #1;
    chk("R7 hold kept", hold, 1);
    idle_all();

    // R8 loop back
    mode = 3; ramp = 0; pin = 1; tick();
    chk("R8 first jump", {jump, jump_ramp}, {1'b1, 2'd2});
    tick();
    ramp = 3; ramp_end = 1; #1;
    chk("R8 loop jump", {jump, jump_ramp}, {1'b1, 2'd2});
    ramp = 2; #1;
    chk("R8 dt end no jump", jump, 0);
    ramp_end = 0; pin = 0; tick(); tick();
    ramp = 3; ramp_end = 1; #1;
    chk("R8 released no jump", jump, 0);
    idle_all();

    // R10 single jump while held active
    mode = 5; ramp = 2; pin = 1; tick(); tick();
    n = 0;
    repeat (4) begin ramp_end = 1; tick(); n += jump + hold; end
    chk("R10 no repeat", n, 0);
    idle_all();

    // R11 fault ignored during halt, run_set releases
    mode = 7; pin = 1; tick(); tick();
    pin = 0; tick(); pin = 1; tick(); tick(); pin = 0; tick(); tick();
    chk("R11 stays halted", {halt, off, hold}, 3'b111);
    run_set = 1; tick(); run_set = 0; #1;
    chk("R11 released", {halt, off, hold}, 0);

    // R5 edge retrigger
    mode = 1; edge_rtg = 1; ramp = 1; pin = 1; tick();
    chk("R5 restart", {restart, jump}, 2'b10);
    tick();
    chk("R5 single pulse", {restart, hold}, 0);
    pin = 0; tick(); tick(); pin = 1; tick();
    chk("R5 second edge", restart, 1);
    pin = 0; tick(); tick();
    run_clr = 1; tick(); run_clr = 0;
    pin = 1; tick();
    chk("R5 no restart in halt", restart, 0);
    edge_rtg = 0; idle_all();

    // R12 run_clr cancels wait, beats run_set
    mode = 1; pin = 1; tick(); tick();
    chk("R12 waiting", hold, 1);
    run_clr = 1; run_set = 1; tick(); run_clr = 0; run_set = 0; #1;
    chk("R12 halted", halt, 1);
    pin = 0; tick(); run_set = 1; tick(); run_set = 0; #1;
    chk("R12 resumed", {halt, hold}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule